// File: doc/BRIEF.md
# Serial EEPROM Boot Register Loader

After reset release this block fetches a 25-byte initialization image from a two-wire serial EEPROM and turns it into masked register-field writes. It works as the bus master. It sends a dummy write of word address 00h, then a repeated START, then one sequential read of the whole image. SCL comes from the system clock through a parameterized quarter-period divider.

Byte 0 of the image is a gate. When the gate allows loading, bytes 1 to 24 are emitted in offset order on a valid/ready write stream. Each write carries a register selector, a 32-bit lane mask and 32-bit data. Some entries keep only part of their byte. Some move source bits into other destination positions, so a write may touch only a few scattered bits of its target.

The write stream follows valid/ready rules. A write is taken on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the offered write stays unchanged, and the loader waits as long as needed. The `busy`, `done` and `error` pins are plain levels.

Top module: `eeprom_boot_loader`

## Requirements
- R1: From reset release until loading ends, `busy` is 1 and `done` is 0. After loading ends, `done` is 1 and `busy` is 0. Both hold until the next reset, and `error` also holds once set.
- R2: On the bus the master sends, in order: START, byte A0h (device 1010000b, write), word address 00h, repeated START, byte A1h (read), 25 data bytes, then STOP. The master ACKs (SDA low) every data byte except the 25th, which it NACKs (SDA high).
- R3: If image byte 0 is 01h, exactly 24 writes follow, one per image offset 1..24 in ascending order, and `error` stays 0.
- R4: If image byte 0 is FFh, no write is issued and `error` stays 0.
- R5: Any other value of image byte 0 sets `error` and issues no write.
- R6: If the slave leaves any address byte or the word-address byte un-ACKed, the master sends STOP at once, sets `error`, ends with `done`, and issues no write.
- R7: The offset maps to `wr_sel` as follows: 1→0, 2–3→1, 4–5→2, 6–9→3, 10–12→4, 13–16→5, 17→6, 18→7, 19→8, 20→9, 21→10, 22→11, 23→12, 24→13.
- R8: Partial and remapped entries (s = the source byte):
  - Offset 1 has mask 0x167, with bit 8 = s7 and bits 6,5,2,1,0 taken from the same source bits.
  - Offset 6 has mask 0xFE.
  - Offset 16 writes bits 27:24 from s3:0.
  - Offset 17 has mask 0xC0.
  - Offset 18 writes bit 7 = s7 and bit 5 = s6.
  - Offset 19 has mask 0x4F.
  - Offset 20 has mask 0x9F.
  - Offset 21 writes bit 15 = s7.
  - Offsets 23 and 24 write bit 27 = s3.
  - Data bits outside the mask are 0.
- R9: Whole-byte entries place the byte into the lane of their multi-byte register, least-significant byte first:
  - Offsets 2/4/10/13/22 use lane 0.
  - Offsets 3/5/7/11/14 use lane 1.
  - Offsets 8/15 use lane 2.
  - Offsets 9/12 use lane 3.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_sel`, `wr_mask` and `wr_data` stay stable. No write is lost or repeated under back-pressure.
- R11: SCL and SDA never change in the same clock cycle, and SDA changes while SCL is high only for START and STOP. One data bit on SCL lasts 4*CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_o | output | 1 | SCL level; 1 means released to the pull-up |
| sda_o | output | 1 | SDA drive; 1 means released, 0 pulls low |
| sda_i | input | 1 | Sensed SDA line level |
| wr_valid | output | 1 | A register-field write is offered |
| wr_ready | input | 1 | The register bank accepts the write |
| wr_sel | output | 4 | Target register selector (R7) |
| wr_mask | output | 32 | Destination bits written |
| wr_data | output | 32 | Destination values, zero outside the mask |
| busy | output | 1 | Loading in progress |
| done | output | 1 | Loading finished (sticky) |
| error | output | 1 | Bad gate byte or missing slave ACK (sticky) |

## Verification
The bench builds the loader with CLK_DIV = 4 and the default device address 1010000b. This gives a 16-cycle SCL bit, so a full 25-byte boot takes only a few thousand cycles. Several complete boots fit in one run: a patterned image under irregular back-pressure, an all-ones image that exposes every mask, both non-loading gate values, and a slave that refuses its address. The slave model reacts one clock after each SCL edge, which this divider still leaves enough margin for.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
  localparam int IMG_BYTES = 25;
  localparam int IDX_W     = $clog2(IMG_BYTES);
  localparam int SEL_W     = 4;
  localparam logic [7:0] GATE_LOAD = 8'h01;
  localparam logic [7:0] GATE_SKIP = 8'hFF;

  typedef enum logic [1:0] {OP_START, OP_WRITE, OP_READ, OP_STOP} i2c_op_e;
endpackage

// File: rtl/bootld_i2c_engine.sv
module bootld_i2c_engine
  import bootld_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  i2c_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_nack,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       rx_nack,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

  typedef enum logic [1:0] {E_IDLE, E_START, E_BITS, E_STOP} eng_e;

  eng_e          st;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [3:0]    bidx;
  logic [8:0]    tx_sh;
  logic [8:0]    rx_sh;
  logic          tick;
  logic          scl_n, sda_n;

  assign tick      = (cnt == CNT_LAST);
  assign cmd_ready = (st == E_IDLE);
  assign done      = (st != E_IDLE) && tick && (ph == 2'd3) &&
                     ((st != E_BITS) || (bidx == 4'd8));
  assign rx_byte   = rx_sh[8:1];
  assign rx_nack   = rx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= E_IDLE;
      cnt   <= '0;
      ph    <= '0;
      bidx  <= '0;
      tx_sh <= '1;
      rx_sh <= '0;
    end else if (st == E_IDLE) begin
      if (cmd_valid) begin
        cnt   <= '0;
        ph    <= '0;
        bidx  <= '0;
        tx_sh <= (cmd_op == OP_WRITE) ? {cmd_byte, 1'b1} : {8'hFF, cmd_nack};
        case (cmd_op)
          OP_START: st <= E_START;
          OP_STOP:  st <= E_STOP;
          default:  st <= E_BITS;
        endcase
      end
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        if (st == E_BITS && ph == 2'd1) rx_sh <= {rx_sh[7:0], sda_i};
        if (ph == 2'd3) begin
          if (st == E_BITS && bidx != 4'd8) begin
            bidx  <= bidx + 4'd1;
            tx_sh <= {tx_sh[7:0], 1'b1};
            ph    <= 2'd0;
          end else begin
            st <= E_IDLE;
          end
        end else begin
          ph <= ph + 2'd1;
        end
      end
    end
  end

  // Quarter-phase waveform; idle holds the last levels.
  always_comb begin
    scl_n = scl_o;
    sda_n = sda_o;
    case (st)
      E_START: begin
        scl_n = (ph == 2'd1) || (ph == 2'd2);
        sda_n = (ph < 2'd2);
      end
      E_BITS: begin
        scl_n = (ph == 2'd1) || (ph == 2'd2);
        sda_n = tx_sh[8];
      end
      E_STOP: begin
        scl_n = (ph != 2'd0);
        sda_n = (ph >= 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_o <= 1'b1;
      sda_o <= 1'b1;
    end else begin
      scl_o <= scl_n;
      sda_o <= sda_n;
    end
  end
endmodule

// File: rtl/bootld_seq.sv
module bootld_seq
  import bootld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output i2c_op_e          cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             eng_done,
  input  logic [7:0]       rx_byte,
  input  logic             rx_nack,
  output logic             ent_valid,
  input  logic             ent_ready,
  output logic [IDX_W-1:0] ent_idx,
  output logic [7:0]       ent_byte,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(IMG_BYTES - 1);

  typedef enum logic [3:0] {
    S_START, S_DEVW, S_WADDR, S_RSTART, S_DEVR,
    S_READ, S_STOP, S_CHECK, S_EMIT, S_FIN
  } seq_e;

  seq_e             st;
  logic             pend, err_q, abort_q, launch_st;
  logic [IDX_W-1:0] cnt;
  logic [7:0]       img [IMG_BYTES];

  always_comb begin
    cmd_op    = OP_START;
    cmd_byte  = 8'h00;
    cmd_nack  = 1'b0;
    launch_st = 1'b1;
    case (st)
      S_START, S_RSTART: cmd_op = OP_START;
      S_DEVW:  begin cmd_op = OP_WRITE; cmd_byte = {DEV_ADDR, 1'b0}; end
      S_WADDR: begin cmd_op = OP_WRITE; cmd_byte = 8'h00; end
      S_DEVR:  begin cmd_op = OP_WRITE; cmd_byte = {DEV_ADDR, 1'b1}; end
      S_READ:  begin cmd_op = OP_READ;  cmd_nack = (cnt == LAST); end
      S_STOP:  cmd_op = OP_STOP;
      default: launch_st = 1'b0;
    endcase
  end

  assign cmd_valid = launch_st && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_START;
      pend    <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      cnt     <= '0;
    end else begin
      if (cmd_valid && cmd_ready) pend <= 1'b1;
      if (eng_done) begin
        pend <= 1'b0;
        case (st)
          S_START:  st <= S_DEVW;
          S_DEVW:   if (rx_nack) begin abort_q <= 1'b1; st <= S_STOP; end
                    else st <= S_WADDR;
          S_WADDR:  if (rx_nack) begin abort_q <= 1'b1; st <= S_STOP; end
                    else st <= S_RSTART;
          S_RSTART: st <= S_DEVR;
          S_DEVR:   if (rx_nack) begin abort_q <= 1'b1; st <= S_STOP; end
                    else begin cnt <= '0; st <= S_READ; end
          S_READ:   if (cnt == LAST) st <= S_STOP;
                    else cnt <= cnt + 1'b1;
          S_STOP:   if (abort_q) begin err_q <= 1'b1; st <= S_FIN; end
                    else st <= S_CHECK;
          default: ;
        endcase
      end
      case (st)
        S_CHECK: begin
          if (img[0] == GATE_LOAD) begin
            cnt <= IDX_W'(1);
            st  <= S_EMIT;
          end else begin
            err_q <= (img[0] != GATE_SKIP);
            st    <= S_FIN;
          end
        end
        S_EMIT: if (ent_ready) begin
          if (cnt == LAST) st <= S_FIN;
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (eng_done && st == S_READ) img[cnt] <= rx_byte;
  end

  assign ent_valid = (st == S_EMIT);
  assign ent_idx   = cnt;
  assign ent_byte  = img[cnt];
  assign done      = (st == S_FIN);
  assign busy      = !done;
  assign error     = err_q;
endmodule

// File: rtl/bootld_field_map.sv
module bootld_field_map
  import bootld_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       b,
  output logic [SEL_W-1:0] sel,
  output logic [31:0]      mask,
  output logic [31:0]      data
);
  logic [31:0] raw;

  always_comb begin
    sel  = '0;
    mask = '0;
    raw  = {4{b}};
    case (idx)
      5'd1:  begin sel = 4'd0;  mask = 32'h0000_0167;
                   raw = {23'b0, b[7], 1'b0, b[6], b[5], 2'b0, b[2:0]}; end
      5'd2:  begin sel = 4'd1;  mask = 32'h0000_00FF; end
      5'd3:  begin sel = 4'd1;  mask = 32'h0000_FF00; end
      5'd4:  begin sel = 4'd2;  mask = 32'h0000_00FF; end
      5'd5:  begin sel = 4'd2;  mask = 32'h0000_FF00; end
      5'd6:  begin sel = 4'd3;  mask = 32'h0000_00FE; end
      5'd7:  begin sel = 4'd3;  mask = 32'h0000_FF00; end
      5'd8:  begin sel = 4'd3;  mask = 32'h00FF_0000; end
      5'd9:  begin sel = 4'd3;  mask = 32'hFF00_0000; end
      5'd10: begin sel = 4'd4;  mask = 32'h0000_00FF; end
      5'd11: begin sel = 4'd4;  mask = 32'h0000_FF00; end
      5'd12: begin sel = 4'd4;  mask = 32'hFF00_0000; end
      5'd13: begin sel = 4'd5;  mask = 32'h0000_00FF; end
      5'd14: begin sel = 4'd5;  mask = 32'h0000_FF00; end
      5'd15: begin sel = 4'd5;  mask = 32'h00FF_0000; end
      5'd16: begin sel = 4'd5;  mask = 32'h0F00_0000;
                   raw = {4'b0, b[3:0], 24'b0}; end
      5'd17: begin sel = 4'd6;  mask = 32'h0000_00C0; end
      5'd18: begin sel = 4'd7;  mask = 32'h0000_00A0;
                   raw = {24'b0, b[7], 1'b0, b[6], 5'b0}; end
      5'd19: begin sel = 4'd8;  mask = 32'h0000_004F; end
      5'd20: begin sel = 4'd9;  mask = 32'h0000_009F; end
      5'd21: begin sel = 4'd10; mask = 32'h0000_8000;
                   raw = {16'b0, b[7], 15'b0}; end
      5'd22: begin sel = 4'd11; mask = 32'h0000_00FF; end
      5'd23: begin sel = 4'd12; mask = 32'h0800_0000;
                   raw = {4'b0, b[3], 27'b0}; end
      5'd24: begin sel = 4'd13; mask = 32'h0800_0000;
                   raw = {4'b0, b[3], 27'b0}; end
      default: ;
    endcase
  end

  assign data = raw & mask;
endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
  import bootld_pkg::*;
#(
  parameter int         CLK_DIV  = 8,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        scl_o,
  output logic        sda_o,
  input  logic        sda_i,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [3:0]  wr_sel,
  output logic [31:0] wr_mask,
  output logic [31:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic        error
);
  logic             cmd_valid, cmd_ready, cmd_nack, eng_done, rx_nack;
  i2c_op_e          cmd_op;
  logic [7:0]       cmd_byte, rx_byte, ent_byte;
  logic [IDX_W-1:0] ent_idx;

  bootld_i2c_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .done(eng_done), .rx_byte(rx_byte), .rx_nack(rx_nack),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  bootld_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .eng_done(eng_done), .rx_byte(rx_byte), .rx_nack(rx_nack),
    .ent_valid(wr_valid), .ent_ready(wr_ready),
    .ent_idx(ent_idx), .ent_byte(ent_byte),
    .busy(busy), .done(done), .error(error)
  );

  bootld_field_map u_map (
    .idx(ent_idx), .b(ent_byte),
    .sel(wr_sel), .mask(wr_mask), .data(wr_data)
  );
endmodule

// File: rtl/bootld_checker.sv
module bootld_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_o,
  input logic        sda_o,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [3:0]  wr_sel,
  input logic [31:0] wr_mask,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic        done,
  input logic        error
);
  assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !busy);

  assert_busy_until_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> busy);

  assert_error_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  assert_write_only_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy && !error);

  assert_data_inside_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data & ~wr_mask) == 32'h0) && (wr_mask != 32'h0));

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_sel) &&
                                $stable(wr_mask) && $stable(wr_data));

  assert_no_joint_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o != $past(scl_o)) |-> (sda_o == $past(sda_o)));
endmodule

bind eeprom_boot_loader bootld_checker u_chk (.*);

// File: tb/tb_eeprom_boot_loader.sv
module tb_eeprom_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_ready = 1'b1;
  logic scl_o, sda_o, wr_valid, busy, done, error;
  logic [3:0]  wr_sel;
  logic [31:0] wr_mask, wr_data;
  logic sda_s;
  wire  sda_line = sda_o & sda_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_boot_loader #(.CLK_DIV(DIV), .DEV_ADDR(7'h50)) dut (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel),
    .wr_mask(wr_mask), .wr_data(wr_data), .busy(busy), .done(done), .error(error)
  );

  // {source byte, selector, mask, expected data} for offsets 1..24
  localparam logic [75:0] VEC [24] = '{
    {8'hA5, 4'd0,  32'h0000_0167, 32'h0000_0125},
    {8'h34, 4'd1,  32'h0000_00FF, 32'h0000_0034},
    {8'h12, 4'd1,  32'h0000_FF00, 32'h0000_1200},
    {8'h78, 4'd2,  32'h0000_00FF, 32'h0000_0078},
    {8'h56, 4'd2,  32'h0000_FF00, 32'h0000_5600},
    {8'hCB, 4'd3,  32'h0000_00FE, 32'h0000_00CA},
    {8'hD0, 4'd3,  32'h0000_FF00, 32'h0000_D000},
    {8'h0E, 4'd3,  32'h00FF_0000, 32'h000E_0000},
    {8'hF1, 4'd3,  32'hFF00_0000, 32'hF100_0000},
    {8'h44, 4'd4,  32'h0000_00FF, 32'h0000_0044},
    {8'h29, 4'd4,  32'h0000_FF00, 32'h0000_2900},
    {8'h86, 4'd4,  32'hFF00_0000, 32'h8600_0000},
    {8'h10, 4'd5,  32'h0000_00FF, 32'h0000_0010},
    {8'h32, 4'd5,  32'h0000_FF00, 32'h0000_3200},
    {8'h54, 4'd5,  32'h00FF_0000, 32'h0054_0000},
    {8'h9B, 4'd5,  32'h0F00_0000, 32'h0B00_0000},
    {8'h7F, 4'd6,  32'h0000_00C0, 32'h0000_0040},
    {8'h40, 4'd7,  32'h0000_00A0, 32'h0000_0020},
    {8'hB5, 4'd8,  32'h0000_004F, 32'h0000_0005},
    {8'h6E, 4'd9,  32'h0000_009F, 32'h0000_000E},
    {8'h80, 4'd10, 32'h0000_8000, 32'h0000_8000},
    {8'h3D, 4'd11, 32'h0000_00FF, 32'h0000_003D},
    {8'h08, 4'd12, 32'h0800_0000, 32'h0800_0000},
    {8'hF7, 4'd13, 32'h0800_0000, 32'h0000_0000}
  };

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [7:0] img [25];
  logic scl_p, sda_p, nack_addr, last_mack, rd_ok;
  logic [7:0] rsh, waddr_seen;
  int role, bcnt, ptr, tx_bytes, starts, stops;

  always @(posedge clk) begin
    scl_p <= scl_o;
    sda_p <= sda_line;
    if (!rst_n) begin
      role = 0; bcnt = 0; ptr = 0; sda_s <= 1'b1;
    end else if (scl_o && scl_p && sda_p && !sda_line) begin
      role = 1; bcnt = 0; sda_s <= 1'b1; starts++;
    end else if (scl_o && scl_p && !sda_p && sda_line) begin
      role = 0; sda_s <= 1'b1; stops++;
    end else if (scl_o && !scl_p) begin
      if (role == 1 || role == 2) begin
        if (bcnt < 8) rsh = {rsh[6:0], sda_line};
        bcnt++;
      end else if (role == 3) begin
        if (bcnt == 8) last_mack = sda_line;
        bcnt++;
      end
    end else if (!scl_o && scl_p) begin
      if ((role == 1 || role == 2) && bcnt == 8) begin
        if (role == 1 && (rsh[7:1] != 7'h50 || nack_addr)) begin role = 4; sda_s <= 1'b1; end
        else sda_s <= 1'b0;
      end else if ((role == 1 || role == 2) && bcnt == 9) begin
        if (role == 1 && rsh[0]) begin role = 3; bcnt = 0; rd_ok = 1'b1; sda_s <= img[ptr][7]; end
        else if (role == 1) begin role = 2; bcnt = 0; sda_s <= 1'b1; end
        else begin ptr = int'(rsh); waddr_seen = rsh; role = 4; sda_s <= 1'b1; end
      end else if (role == 3) begin
        if (bcnt < 8) sda_s <= img[ptr][7-bcnt];
        else if (bcnt == 8) sda_s <= 1'b1;
        else begin
          tx_bytes++;
          if (!last_mack && ptr < 24) begin ptr++; bcnt = 0; sda_s <= img[ptr][7]; end
          else begin role = 4; sda_s <= 1'b1; end
        end
      end
    end
  end

  // ---------------- monitors ----------------
  int wcnt, stall_cycles, cyc, last_rise, min_period;
  int rdy_mode;
  logic [3:0]  gsel  [32];
  logic [31:0] gmask [32];
  logic [31:0] gdata [32];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    wr_ready <= (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 1);
  end

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (wcnt < 32) begin gsel[wcnt] = wr_sel; gmask[wcnt] = wr_mask; gdata[wcnt] = wr_data; end
      wcnt++;
    end
    if (rst_n && wr_valid && !wr_ready) stall_cycles++;
    if (rst_n && scl_o && !scl_p) begin
      if (last_rise > 0 && (cyc - last_rise) < min_period) min_period = cyc - last_rise;
      last_rise = cyc;
    end
  end

  task automatic load_image(input logic [7:0] gate, input bit ones);
    img[0] = gate;
    for (int k = 1; k < 25; k++) img[k] = ones ? 8'hFF : VEC[k-1][75:68];
  endtask

  task automatic boot(input bit check_reset);
    rst_n = 1'b0;
    wcnt = 0; stall_cycles = 0; tx_bytes = 0; starts = 0; stops = 0;
    last_mack = 1'b0; rd_ok = 1'b0; waddr_seen = 8'hEE; last_rise = 0; min_period = 1000;
    repeat (4) @(negedge clk);
    if (check_reset) begin
      check(busy && !done && !error, "R1 reset state", {busy, done, error}, 3'b100);
      check(scl_o && sda_o && !wr_valid, "R11 reset bus idle", {scl_o, sda_o, wr_valid}, 3'b110);
    end
    rst_n = 1'b1;
    for (int n = 0; n < 30000 && !done; n++) @(negedge clk);
    check(done, "R1 watchdog: done reached", done, 1);
    repeat (20) @(negedge clk);
    check(done && !busy, "R1 done holds", {done, busy}, 2'b10);
  endtask

  initial begin
    rdy_mode = 1; nack_addr = 1'b0; cyc = 0;
    // Image A, gate 01h, irregular back-pressure: table walk
    load_image(8'h01, 1'b0);
    boot(1'b1);
    check(!error, "R3 no error on load", error, 0);
    check(wcnt == 24, "R3 write count", wcnt, 24);
    check(stall_cycles > 0, "R10 back-pressure exercised", stall_cycles, 1);
    for (int k = 0; k < 24; k++) begin
      check(gsel[k] == VEC[k][67:64], $sformatf("R7 sel offset %0d", k+1), gsel[k], VEC[k][67:64]);
      check(gmask[k] == VEC[k][63:32], $sformatf("R8 mask offset %0d", k+1), gmask[k], VEC[k][63:32]);
      check(gdata[k] == VEC[k][31:0], $sformatf("R9 data offset %0d", k+1), gdata[k], VEC[k][31:0]);
    end
    check(starts == 2 && stops == 1, "R2 start/stop count", {starts[7:0], stops[7:0]}, 16'h0201);
    check(waddr_seen == 8'h00 && rd_ok, "R2 word address and read phase", waddr_seen, 0);
    check(tx_bytes == 25, "R2 bytes read", tx_bytes, 25);
    check(last_mack == 1'b1, "R2 NACK on last byte", last_mack, 1);
    check(min_period == 4*DIV, "R11 SCL bit period", min_period, 4*DIV);

    // Image of all ones: data equals mask
    rdy_mode = 0;
    load_image(8'h01, 1'b1);
    boot(1'b0);
    check(wcnt == 24, "R3 write count ones image", wcnt, 24);
    for (int k = 0; k < 24; k++)
      check(gdata[k] == VEC[k][63:32], $sformatf("R8 ones data offset %0d", k+1), gdata[k], VEC[k][63:32]);

    // Gate FFh: skip
    load_image(8'hFF, 1'b0);
    boot(1'b0);
    check(wcnt == 0 && !error, "R4 skip gate", {wcnt[7:0], error}, 0);
    check(tx_bytes == 25, "R2 full read on skip", tx_bytes, 25);

    // Invalid gate
    load_image(8'h5A, 1'b0);
    boot(1'b0);
    check(wcnt == 0, "R5 no writes on bad gate", wcnt, 0);
    check(error, "R5 error on bad gate", error, 1);
    load_image(8'h00, 1'b0);
    boot(1'b0);
    check(wcnt == 0 && error, "R5 gate 00h rejected", {wcnt[7:0], error}, 1);

    // Slave refuses its address
    nack_addr = 1'b1;
    load_image(8'h01, 1'b0);
    boot(1'b0);
    check(error && wcnt == 0, "R6 abort on missing ACK", {wcnt[7:0], error}, 1);
    check(stops == 1 && tx_bytes == 0, "R6 STOP after abort", {stops[7:0], tx_bytes[7:0]}, 16'h0100);
    check(scl_o && sda_line, "R6 bus released", {scl_o, sda_line}, 2'b11);
    repeat (30) @(negedge clk);
    check(error && done, "R1 error sticky", {error, done}, 2'b11);
    nack_addr = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R1 global watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule